// File: doc/BRIEF.md
# Nx64 Timeslot Receive Demapper

This block sits behind a T1 or E1 framer. It picks user data out of a contiguous window of timeslots in the incoming serial frame and hands it to the user interface one bit at a time, in the user clock domain. The frame side supplies its own clock, a sync strobe that marks the first bit of every frame, and the data bit. The window is set by a starting timeslot and a slot count, and the frame format is T1 or E1. A dual-clock FIFO carries the bits between the two clock domains. Its read side stays idle until the FIFO is half full, so that a burst of slots cannot drain it right after start-up.

In 56 kbps mode only the starting slot is used. Its first seven bits carry data. Its eighth bit carries an overhead stream, and that stream spells out an address word spread over successive frames. When address checking is on, each word is tested for a zero marker, odd parity and a match with the configured address. A status flag follows the run of good and bad words. When squelching is also on and the status is not valid, every data bit delivered is forced to one.

Top module: `nx64_rx_demap`

## Requirements
- R1: T1 format: a frame holds 193 bits. The bit that arrives with `f_sync` is position 0, a framing bit that is never delivered. Slot s occupies positions 1+8s to 8+8s. Outside 56 kbps mode, slots `cfg_start` to `cfg_start+cfg_n-1` are delivered. Slots numbered 24 or higher do not exist.
- R2: E1 format (`cfg_e1`=1): a frame holds 256 bits. Slot s occupies positions 8s to 8s+7. The same window rule as R1 applies.
- R3: With `cfg_56k`=1, only slot `cfg_start` is used and `cfg_n` is ignored. Its bits 0 to 6, in order of arrival, are delivered. Its bit 7 is an overhead bit and is never delivered.
- R4: The overhead bits form words of ADDR_W+2 bits, one bit per frame. Words are counted from the first `f_sync` after reset. The first bit of a word is a marker, then come the address bits MSB first, then a parity bit. A word is good when the marker is 0, the address bits plus the parity bit hold an odd number of ones, and the address equals `cfg_addr`.
- R5: `f_addr_ok` is 0 after reset. It rises after 3 good words in a row and falls after 3 bad words in a row. It changes only at the overhead bit that ends a word, and it stays 0 unless both `cfg_56k` and `cfg_addr_en` are set.
- R6: With `cfg_56k`, `cfg_addr_en` and `cfg_squelch` all set, any data bit received while `f_addr_ok` is 0 is delivered as 1. With `cfg_squelch` clear, data passes unchanged.
- R7: No bit is delivered until the FIFO has held DEPTH/2 bits. After that, each `u_take` pulse with data present yields `u_valid`=1 and the bit in the next user clock cycle. A pulse while the FIFO is empty yields `u_valid`=0.
- R8: In reset, `u_valid`=0, `u_bit`=1 and `f_addr_ok`=0.
- R9: Selected bits leave in their order of arrival, with none lost or added, as long as the user side takes bits faster than the frame side writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| f_clk | input | 1 | Frame-side bit clock |
| f_rst_n | input | 1 | Frame-side asynchronous reset, active low |
| f_sync | input | 1 | High with the first bit of each frame |
| f_data | input | 1 | Frame data bit |
| cfg_e1 | input | 1 | 1 = E1 frame, 0 = T1 frame |
| cfg_56k | input | 1 | 56 kbps single-slot mode |
| cfg_start | input | 5 | First timeslot of the window |
| cfg_n | input | 6 | Number of timeslots in the window |
| cfg_addr_en | input | 1 | Enable address checking (56 kbps mode) |
| cfg_squelch | input | 1 | Force ones while the address is not valid |
| cfg_addr | input | ADDR_W | Expected receive address |
| f_addr_ok | output | 1 | Address valid status, frame clock domain |
| u_clk | input | 1 | User interface clock |
| u_rst_n | input | 1 | User-side asynchronous reset, active low |
| u_take | input | 1 | Request for one bit |
| u_valid | output | 1 | A bit was delivered this cycle |
| u_bit | output | 1 | Delivered bit, 1 when idle |

## Verification
The assertions assume that the configuration changes only while both resets are held. They also assume that `f_sync` arrives exactly once per frame length and that the user side drains the FIFO faster than the selected slots fill it, so the FIFO never overflows. The bench sets each configuration inside a reset and drives frames of the exact length, with the sync on position 0. It stops the frame clock between runs and keeps the user clock at 100 MHz against a slower frame clock, with requests drawn at a seven-in-eight rate.

// File: rtl/nx64_rx_pkg.sv
package nx64_rx_pkg;

   localparam int unsigned T1_BITS   = 193;
   localparam int unsigned E1_BITS   = 256;

   typedef struct packed {
      logic       present;
      logic [4:0] slot;
      logic [2:0] bitn;
   } slot_pos_t;

   // Map a bit position within the frame to slot and bit number.
   function automatic slot_pos_t decode_pos(input logic [8:0] pos, input logic e1);
      slot_pos_t  r;
      logic [7:0] idx;
      if (e1) begin
         r.present = 1'b1;
         idx       = pos[7:0];
      end else begin
         r.present = (pos != 9'd0);
         idx       = pos[7:0] - 8'd1;
      end
      r.slot = idx[7:3];
      r.bitn = idx[2:0];
      return r;
   endfunction

endpackage

// File: rtl/nx64_rx_slot_sel.sv
module nx64_rx_slot_sel
   import nx64_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       f_sync,
   input  logic       cfg_e1,
   input  logic       cfg_56k,
   input  logic [4:0] cfg_start,
   input  logic [5:0] cfg_n,
   output logic       data_en,
   output logic       ovh_en
);

   logic [8:0] nxt_q;
   logic [8:0] pos;
   logic [8:0] last_pos;
   logic       synced_q;
   logic       live;
   logic       at_start;
   logic       in_win;
   slot_pos_t  dp;

   always_comb begin
      pos      = f_sync ? 9'd0 : nxt_q;
      last_pos = cfg_e1 ? 9'(E1_BITS - 1) : 9'(T1_BITS - 1);
      live     = f_sync | synced_q;
      dp       = decode_pos(pos, cfg_e1);
      at_start = (dp.slot == cfg_start);
      in_win   = ({2'b00, dp.slot} >= {2'b00, cfg_start}) &&
                 ({2'b00, dp.slot} <  ({2'b00, cfg_start} + {1'b0, cfg_n}));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt_q    <= '0;
         synced_q <= 1'b0;
      end else begin
         if (live)
            nxt_q <= (pos == last_pos) ? 9'd0 : pos + 9'd1;
         if (f_sync)
            synced_q <= 1'b1;
      end
   end

   assign data_en = live & dp.present &
                    (cfg_56k ? (at_start & (dp.bitn != 3'd7)) : in_win);
   assign ovh_en  = live & dp.present & cfg_56k & at_start & (dp.bitn == 3'd7);

endmodule

// File: rtl/nx64_rx_addr_check.sv
module nx64_rx_addr_check #(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned RUN_OK  = 3,
   parameter int unsigned RUN_BAD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f_sync,
   input  logic              enable,
   input  logic [ADDR_W-1:0] exp_addr,
   input  logic              ovh_en,
   input  logic              ovh_bit,
   output logic              addr_ok,
   output logic              word_done
);

   localparam int unsigned WL     = ADDR_W + 2;
   localparam int unsigned PW     = $clog2(WL);
   localparam int unsigned RUN_MX = (RUN_OK > RUN_BAD) ? RUN_OK : RUN_BAD;
   localparam int unsigned CW     = $clog2(RUN_MX + 1);

   logic [PW-1:0] wp_q;
   logic          wsync_q;
   logic [WL-2:0] sh_q;
   logic [WL-1:0] word;
   logic          good;
   logic [CW-1:0] good_c;
   logic [CW-1:0] bad_c;

   assign word      = {sh_q, ovh_bit};
   assign word_done = enable & ovh_en & (wp_q == PW'(WL - 1));
   assign good      = ~word[WL-1] & (^word[WL-2:0]) & (word[WL-2:1] == exp_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         wsync_q <= 1'b0;
      end else if (f_sync) begin
         wsync_q <= 1'b1;
         if (!wsync_q || wp_q == PW'(WL - 1))
            wp_q <= '0;
         else
            wp_q <= wp_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (enable && ovh_en && !word_done)
         sh_q <= {sh_q[WL-3:0], ovh_bit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_c  <= '0;
         bad_c   <= '0;
         addr_ok <= 1'b0;
      end else if (word_done) begin
         if (good) begin
            bad_c <= '0;
            if (good_c != CW'(RUN_OK))
               good_c <= good_c + 1'b1;
            if (good_c >= CW'(RUN_OK - 1))
               addr_ok <= 1'b1;
         end else begin
            good_c <= '0;
            if (bad_c != CW'(RUN_BAD))
               bad_c <= bad_c + 1'b1;
            if (bad_c >= CW'(RUN_BAD - 1))
               addr_ok <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nx64_rx_sync_bus.sv
module nx64_rx_sync_bus #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[i] <= '0;
         else if (i == 0)
            stage_q[i] <= d;
         else
            stage_q[i] <= stage_q[(i == 0) ? 0 : i - 1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/nx64_rx_fifo.sv
module nx64_rx_fifo #(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DEPTH),
   localparam int unsigned PW         = AW + 1
) (
   input  logic          w_clk,
   input  logic          w_rst_n,
   input  logic          w_en,
   input  logic          w_bit,
   output logic [PW-1:0] w_fill,
   input  logic          r_clk,
   input  logic          r_rst_n,
   input  logic          r_take,
   output logic          r_started,
   output logic          r_valid,
   output logic          r_bit
);

   logic          mem [DEPTH];
   logic [PW-1:0] wbin_q, wgray_q, wbin_nx;
   logic [PW-1:0] rbin_q, rgray_q, rbin_nx;
   logic [PW-1:0] rgray_w, rbin_w;
   logic [PW-1:0] wgray_r, wbin_r;
   logic [PW-1:0] r_fill;
   logic          full;
   logic          push;
   logic          pop;

   // Write side
   nx64_rx_sync_bus #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(w_clk), .rst_n(w_rst_n), .d(rgray_q), .q(rgray_w)
   );

   for (genvar i = 0; i < PW; i++) begin : g_rconv
      assign rbin_w[i] = ^(rgray_w >> i);
      assign wbin_r[i] = ^(wgray_r >> i);
   end

   assign w_fill  = wbin_q - rbin_w;
   assign full    = (w_fill == PW'(DEPTH));
   assign push    = w_en & ~full;
   assign wbin_nx = wbin_q + 1'b1;

   always_ff @(posedge w_clk or negedge w_rst_n) begin
      if (!w_rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (push) begin
         wbin_q  <= wbin_nx;
         wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   always_ff @(posedge w_clk) begin
      if (push)
         mem[wbin_q[AW-1:0]] <= w_bit;
   end

   // Read side
   nx64_rx_sync_bus #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(r_clk), .rst_n(r_rst_n), .d(wgray_q), .q(wgray_r)
   );

   assign r_fill  = wbin_r - rbin_q;
   assign pop     = r_take & r_started & (r_fill != '0);
   assign rbin_nx = rbin_q + 1'b1;

   always_ff @(posedge r_clk or negedge r_rst_n) begin
      if (!r_rst_n) begin
         rbin_q    <= '0;
         rgray_q   <= '0;
         r_started <= 1'b0;
         r_valid   <= 1'b0;
         r_bit     <= 1'b1;
      end else begin
         if (r_fill >= PW'(DEPTH / 2))
            r_started <= 1'b1;
         r_valid <= pop;
         r_bit   <= pop ? mem[rbin_q[AW-1:0]] : 1'b1;
         if (pop) begin
            rbin_q  <= rbin_nx;
            rgray_q <= rbin_nx ^ (rbin_nx >> 1);
         end
      end
   end

endmodule

// File: rtl/nx64_rx_demap.sv
module nx64_rx_demap
   import nx64_rx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RUN_OK      = 3,
   parameter int unsigned RUN_BAD     = 3
) (
   input  logic              f_clk,
   input  logic              f_rst_n,
   input  logic              f_sync,
   input  logic              f_data,
   input  logic              cfg_e1,
   input  logic              cfg_56k,
   input  logic [4:0]        cfg_start,
   input  logic [5:0]        cfg_n,
   input  logic              cfg_addr_en,
   input  logic              cfg_squelch,
   input  logic [ADDR_W-1:0] cfg_addr,
   output logic              f_addr_ok,
   input  logic              u_clk,
   input  logic              u_rst_n,
   input  logic              u_take,
   output logic              u_valid,
   output logic              u_bit
);

   localparam int unsigned FILL_W = $clog2(DEPTH) + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RUN_OK < 1 || RUN_BAD < 1) begin : g_bad_run
      $error("RUN_OK and RUN_BAD must be at least 1");
   end

   logic              data_en;
   logic              ovh_en;
   logic              word_done;
   logic              sq_active;
   logic              fifo_bit;
   logic [FILL_W-1:0] w_fill;
   logic              r_started;

   nx64_rx_slot_sel u_sel (
      .clk       (f_clk),
      .rst_n     (f_rst_n),
      .f_sync    (f_sync),
      .cfg_e1    (cfg_e1),
      .cfg_56k   (cfg_56k),
      .cfg_start (cfg_start),
      .cfg_n     (cfg_n),
      .data_en   (data_en),
      .ovh_en    (ovh_en)
   );

   nx64_rx_addr_check #(
      .ADDR_W  (ADDR_W),
      .RUN_OK  (RUN_OK),
      .RUN_BAD (RUN_BAD)
   ) u_addr (
      .clk       (f_clk),
      .rst_n     (f_rst_n),
      .f_sync    (f_sync),
      .enable    (cfg_56k & cfg_addr_en),
      .exp_addr  (cfg_addr),
      .ovh_en    (ovh_en),
      .ovh_bit   (f_data),
      .addr_ok   (f_addr_ok),
      .word_done (word_done)
   );

   assign sq_active = cfg_56k & cfg_addr_en & cfg_squelch;
   assign fifo_bit  = (sq_active & ~f_addr_ok) ? 1'b1 : f_data;

   nx64_rx_fifo #(
      .DEPTH       (DEPTH),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fifo (
      .w_clk     (f_clk),
      .w_rst_n   (f_rst_n),
      .w_en      (data_en),
      .w_bit     (fifo_bit),
      .w_fill    (w_fill),
      .r_clk     (u_clk),
      .r_rst_n   (u_rst_n),
      .r_take    (u_take),
      .r_started (r_started),
      .r_valid   (u_valid),
      .r_bit     (u_bit)
   );

endmodule

// File: rtl/nx64_rx_demap_chk.sv
module nx64_rx_demap_chk #(
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned FILL_W = $clog2(DEPTH) + 1
) (
   input logic              f_clk,
   input logic              f_rst_n,
   input logic              u_clk,
   input logic              u_rst_n,
   input logic              cfg_56k,
   input logic              cfg_addr_en,
   input logic              f_addr_ok,
   input logic              word_done,
   input logic              data_en,
   input logic              ovh_en,
   input logic [FILL_W-1:0] w_fill,
   input logic              u_take,
   input logic              u_valid,
   input logic              r_started
);

   assert_no_overflow_R7: assert property (@(posedge f_clk) disable iff (!f_rst_n)
      w_fill <= FILL_W'(DEPTH));

   assert_status_on_word_R5: assert property (@(posedge f_clk) disable iff (!f_rst_n)
      !$stable(f_addr_ok) |-> $past(word_done));

   assert_status_needs_check_R5: assert property (@(posedge f_clk) disable iff (!f_rst_n)
      !(cfg_56k && cfg_addr_en) |-> !f_addr_ok);

   assert_ovh_not_data_R3: assert property (@(posedge f_clk) disable iff (!f_rst_n)
      ovh_en |-> !data_en);

   assert_valid_needs_take_R7: assert property (@(posedge u_clk) disable iff (!u_rst_n)
      u_valid |-> $past(u_take));

   assert_valid_needs_start_R7: assert property (@(posedge u_clk) disable iff (!u_rst_n)
      u_valid |-> $past(r_started));

   assert_start_sticky_R7: assert property (@(posedge u_clk) disable iff (!u_rst_n)
      r_started |=> r_started);

endmodule

bind nx64_rx_demap nx64_rx_demap_chk #(.DEPTH(DEPTH)) u_chk (
   .f_clk       (f_clk),
   .f_rst_n     (f_rst_n),
   .u_clk       (u_clk),
   .u_rst_n     (u_rst_n),
   .cfg_56k     (cfg_56k),
   .cfg_addr_en (cfg_addr_en),
   .f_addr_ok   (f_addr_ok),
   .word_done   (word_done),
   .data_en     (data_en),
   .ovh_en      (ovh_en),
   .w_fill      (w_fill),
   .u_take      (u_take),
   .u_valid     (u_valid),
   .r_started   (r_started)
);

// File: tb/nx64_rx_demap_test.sv
`timescale 1ns/100ps
module nx64_rx_demap_test;

   localparam int ADDR_W = 6;
   localparam int WL     = ADDR_W + 2;

   logic              f_clk = 1'b0, f_rst_n = 1'b0, f_sync = 1'b0, f_data = 1'b0;
   logic              u_clk = 1'b0, u_rst_n = 1'b0, u_take = 1'b0;
   logic              cfg_e1 = 1'b0, cfg_56k = 1'b0, cfg_addr_en = 1'b0, cfg_squelch = 1'b0;
   logic [4:0]        cfg_start = '0;
   logic [5:0]        cfg_n = 6'd1;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic              f_addr_ok, u_valid, u_bit;
   logic              f_run = 1'b1;

   int  total = 0, bad = 0;
   bit  exp_q[$];
   bit  got_q[$];
   bit  st;
   int  gr, br;
   bit  have_prev;
   bit  finished = 1'b0;

   nx64_rx_demap #(.ADDR_W(ADDR_W)) uut (.*);

   always #5 u_clk = ~u_clk;

   initial begin
      forever begin
         #8.5;
         if (f_run || f_clk) f_clk = ~f_clk;
      end
   end

   always @(negedge u_clk) begin
      u_take = ($urandom % 8) != 0;
      if (u_valid) got_q.push_back(u_bit);
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic start_run(input bit e1, input bit m56, input int start, input int n,
                            input bit aen, input bit sq);
      f_run = 1'b1;
      f_rst_n = 1'b0;
      u_rst_n = 1'b0;
      f_sync = 1'b0;
      cfg_e1 = e1; cfg_56k = m56; cfg_start = 5'(start); cfg_n = 6'(n);
      cfg_addr_en = aen; cfg_squelch = sq;
      cfg_addr = 6'($urandom % 64);
      repeat (4) @(negedge f_clk);
      exp_q.delete();
      got_q.delete();
      st = 1'b0; gr = 0; br = 0; have_prev = 1'b0;
      f_rst_n = 1'b1;
      u_rst_n = 1'b1;
   endtask

   task automatic send_frame(input bit ovh);
      int len = cfg_e1 ? 256 : 193;
      bit sq = cfg_56k && cfg_addr_en && cfg_squelch && !st;
      for (int p = 0; p < len; p++) begin
         int slot = -1;
         int b = 0;
         bit d;
         @(negedge f_clk);
         if (p == 0 && have_prev) check(f_addr_ok == st, "R5 status", f_addr_ok, st);
         f_sync = (p == 0);
         d = 1'($urandom % 2);
         if (cfg_e1) begin slot = p / 8; b = p % 8; end
         else if (p > 0) begin slot = (p - 1) / 8; b = (p - 1) % 8; end
         if (cfg_56k) begin
            if (slot == int'(cfg_start) && b == 7) d = ovh;
            if (slot == int'(cfg_start) && b < 7) exp_q.push_back(sq ? 1'b1 : d);
         end else if (slot >= int'(cfg_start) && slot < int'(cfg_start) + int'(cfg_n)) begin
            exp_q.push_back(d);
         end
         f_data = d;
      end
      have_prev = 1'b1;
   endtask

   // kind: 0 good, 1 wrong address, 2 bad parity, 3 bad marker
   function automatic logic [WL-1:0] make_word(input int kind);
      logic [ADDR_W-1:0] a = cfg_addr;
      logic p, m;
      if (kind == 1) a = cfg_addr ^ 6'(1 + $urandom % 63);
      p = ~^a;
      if (kind == 2) p = ~p;
      m = (kind == 3);
      return {m, a, p};
   endfunction

   task automatic send_word(input int kind);
      logic [WL-1:0] w = make_word(kind);
      for (int k = 0; k < WL; k++) send_frame(w[WL-1-k]);
      if (cfg_56k && cfg_addr_en) begin
         if (kind == 0) begin
            gr++; br = 0;
            if (gr >= 3) st = 1'b1;
         end else begin
            br++; gr = 0;
            if (br >= 3) st = 1'b0;
         end
      end
   endtask

   task automatic end_run(input string tag, input bit compare);
      int mism = 0;
      @(negedge f_clk);
      if (have_prev) check(f_addr_ok == st, "R5 status", f_addr_ok, st);
      f_sync = 1'b0;
      f_data = 1'b0;
      f_run = 1'b0;
      repeat (300) @(negedge u_clk);
      if (compare) begin
         check(got_q.size() == exp_q.size(), {tag, " length"}, got_q.size(), exp_q.size());
         for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (got_q[i] != exp_q[i]) mism++;
         check(mism == 0, {tag, " content"}, mism, 0);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin : watchdog
      #1_800_000;
      check(1'b0, "R9 watchdog expired", 0, 1);
      summary();
   end

   initial begin : main
      int start, n;
      void'($urandom(32'd4711));

      // R8 reset state
      repeat (3) @(negedge u_clk);
      check(u_valid == 1'b0, "R8 u_valid", u_valid, 0);
      check(u_bit == 1'b1, "R8 u_bit", u_bit, 1);
      check(f_addr_ok == 1'b0, "R8 f_addr_ok", f_addr_ok, 0);

      // R1 full T1 window, then a window running past slot 23
      start_run(1'b0, 1'b0, 0, 24, 1'b0, 1'b0);
      repeat (4) send_frame(1'b0);
      end_run("R1 full", 1'b1);
      start_run(1'b0, 1'b0, 20, 10, 1'b0, 1'b0);
      repeat (4) send_frame(1'b0);
      end_run("R1 past end", 1'b1);

      // R2 E1 windows
      start_run(1'b1, 1'b0, 5, 3, 1'b0, 1'b0);
      repeat (4) send_frame(1'b0);
      end_run("R2 mid", 1'b1);
      start_run(1'b1, 1'b0, 31, 1, 1'b0, 1'b0);
      repeat (4) send_frame(1'b0);
      end_run("R2 last slot", 1'b1);

      // R3 56k without address checking, cfg_n ignored
      start_run(1'b0, 1'b1, 9, 7, 1'b0, 1'b0);
      repeat (5) send_frame(1'b1);
      end_run("R3 56k", 1'b1);

      // R4 R5 R6 address word runs with squelch
      start_run(1'b0, 1'b1, 3, 1, 1'b1, 1'b1);
      send_word(1); send_word(0); send_word(0); send_word(0); send_word(0);
      send_word(1); send_word(2); send_word(0); send_word(3);
      send_word(1); send_word(2); send_word(0);
      end_run("R6 squelch", 1'b1);

      // R6 squelch off: data passes while status is low
      start_run(1'b1, 1'b1, 17, 1, 1'b1, 1'b0);
      send_word(0); send_word(0); send_word(0);
      send_word(3); send_word(2); send_word(1);
      end_run("R6 no squelch", 1'b1);

      // R4 checking disabled: good words leave status low
      start_run(1'b0, 1'b1, 0, 1, 1'b0, 1'b1);
      send_word(0); send_word(0); send_word(0);
      end_run("R4 disabled", 1'b1);

      // R7 seven bits never reach the start level
      start_run(1'b0, 1'b1, 2, 1, 1'b0, 1'b0);
      send_frame(1'b0);
      end_run("R7", 1'b0);
      check(got_q.size() == 0, "R7 below half fill", got_q.size(), 0);

      // R9 random windows and formats
      for (int r = 0; r < 6; r++) begin
         bit e1 = 1'($urandom % 2);
         bit m56 = 1'($urandom % 4 == 0);
         start = int'($urandom % (e1 ? 32 : 24));
         n = 1 + int'($urandom % 32);
         start_run(e1, m56, start, n, 1'b0, 1'b0);
         repeat (5) send_frame(1'($urandom % 2));
         end_run("R9 random", 1'b1);
      end

      summary();
   end

endmodule